// File: doc/BRIEF.md
# Latched BCD Seven-Segment Decoder with Dimming

This block takes a four-bit binary-coded decimal digit and turns it into the seven active-high segment lines a through g of a numeric display. A code-hold stage either passes the incoming digit through or keeps the last one captured, as set by a hold-enable input. All of it runs on one clock with a synchronous reset, and every segment line comes from a register.

Two active-low overrides act on the display. The lamp-test input lights every segment, and it takes priority over everything else. The blank input darkens the display. A built-in dimmer also darkens the display for part of each 256-cycle period. It compares a free-running counter with a programmable duty value, which lets a host set brightness with one register write and no software pulsing. Digits 0 to 9 get their usual glyphs: six has no top bar and nine has no bottom bar. Codes 10 to 15 give a dark display.

Top module: `seg7_latch_decoder`

## Requirements
- R1: With lamp_test_n low at a clock edge, seg is 7'b1111111 after that edge, whatever blank_n, latch_en, bcd_in, duty or the dimmer are doing.
- R2: With lamp_test_n high and blank_n low at a clock edge, seg is 7'b0000000 after that edge, whatever the code and latch_en are.
- R3: With latch_en low and no override active, seg after an edge shows the glyph of the bcd_in value sampled at that edge.
- R4: With latch_en high, the stored code does not change, and seg shows the code captured at the last edge where latch_en was low. Changes on bcd_in have no effect.
- R5: Codes 10 to 15, whether passed through or stored, drive seg to 7'b0000000.
- R6: seg[6] is segment a and seg[0] is segment g. The glyphs for 0 through 9 are 1111110, 0110000, 1101101, 1111001, 0110011, 1011011, 0011111, 1110000, 1111111 and 1110011.
- R7: An 8-bit counter advances by one on every clock edge out of reset and wraps from 255 to 0. At any edge where its value before the increment is at or above duty, the display is blanked as in R2.
- R8: With duty equal to 0 and lamp_test_n high, seg is all zero. With duty equal to 255, the display is dark on exactly one edge in every 256.
- R9: While rst is high at an edge, seg, the stored code and the counter all clear to zero.
- R10: A code held under latch_en high reappears on seg when blanking or lamp test ends.
- R11: Every change at the inputs reaches seg exactly one clock edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bcd_in | input | 4 | Digit code to show or capture |
| lamp_test_n | input | 1 | Active-low: light all segments |
| blank_n | input | 1 | Active-low: darken the display |
| latch_en | input | 1 | High holds the stored code, low passes bcd_in through |
| duty | input | 8 | Dimmer threshold: counter values below it leave the display lit |
| seg | output | 7 | Registered segments, seg[6]=a down to seg[0]=g |

## Verification
The assertions assume that rst is high at the first clock edge, so that the counter and the output register start from known values. They also assume that every input is settled at each rising edge. The bench holds rst high for several cycles at the start and drives every input on the falling edge, so both assumptions are met. The bench also leaves duty at 255 except in the dimming tests. As a result, the single dark cycle in each period is the only dimmer effect that shows during the decode and hold tests, and the reference model predicts that cycle from its own counter.

// File: rtl/seg7_pkg.sv
package seg7_pkg;
  localparam int CODE_W = 4;
  localparam int SEG_N  = 7;
  localparam int DUTY_W = 8;

  localparam logic [SEG_N-1:0] SEG_ALL_ON  = {SEG_N{1'b1}};
  localparam logic [SEG_N-1:0] SEG_ALL_OFF = '0;

  typedef enum logic [1:0] {
    SRC_GLYPH = 2'd0,
    SRC_DARK  = 2'd1,
    SRC_LAMP  = 2'd2
  } seg_src_e;

  // Segment order: bit 6 = a, bit 0 = g. Codes above 9 map to dark.
  function automatic logic [SEG_N-1:0] glyph_of(input logic [CODE_W-1:0] code);
    logic [SEG_N-1:0] pat;
    unique case (code)
      4'd0:    pat = 7'b1111110;
      4'd1:    pat = 7'b0110000;
      4'd2:    pat = 7'b1101101;
      4'd3:    pat = 7'b1111001;
      4'd4:    pat = 7'b0110011;
      4'd5:    pat = 7'b1011011;
      4'd6:    pat = 7'b0011111;
      4'd7:    pat = 7'b1110000;
      4'd8:    pat = 7'b1111111;
      4'd9:    pat = 7'b1110011;
      default: pat = SEG_ALL_OFF;
    endcase
    return pat;
  endfunction

  function automatic logic code_is_digit(input logic [CODE_W-1:0] code);
    return code <= CODE_W'(9);
  endfunction

  // Dimmer rule: dark once the phase has reached the threshold.
  function automatic logic dim_dark(input logic [DUTY_W-1:0] phase,
                                    input logic [DUTY_W-1:0] thresh);
    return phase >= thresh;
  endfunction

  // Override priority: lamp test first, then any blanking, then the glyph.
  function automatic seg_src_e pick_src(input logic lamp_n, input logic dark);
    if (!lamp_n)   return SRC_LAMP;
    else if (dark) return SRC_DARK;
    else           return SRC_GLYPH;
  endfunction
endpackage

// File: rtl/seg7_code_store.sv
module seg7_code_store
  import seg7_pkg::*;
#(
  parameter int W = CODE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic [W-1:0] code_in,
  output logic [W-1:0] code_q,
  output logic [W-1:0] code_sel
);
  // code_sel is the value the register takes at this edge; the decoder uses it
  // so that a pass-through code reaches the output one cycle after it arrives.
  always_comb code_sel = hold ? code_q : code_in;

  always_ff @(posedge clk) begin
    if (rst) code_q <= '0;
    else     code_q <= code_sel;
  end
endmodule

// File: rtl/seg7_dimmer.sv
module seg7_dimmer
  import seg7_pkg::*;
#(
  parameter int W = DUTY_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] thresh,
  output logic [W-1:0] phase,
  output logic         dark
);
  always_comb dark = dim_dark(phase, thresh);

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= phase + W'(1);
  end
endmodule

// File: rtl/seg7_glyph_stage.sv
module seg7_glyph_stage
  import seg7_pkg::*;
#(
  parameter int N = SEG_N
) (
  input  logic              clk,
  input  logic              rst,
  input  seg_src_e          src,
  input  logic [CODE_W-1:0] code,
  output logic [N-1:0]      seg_q
);
  logic [N-1:0] pattern;
  always_comb pattern = glyph_of(code);

  for (genvar i = 0; i < N; i++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst) seg_q[i] <= 1'b0;
      else begin
        unique case (src)
          SRC_LAMP:  seg_q[i] <= 1'b1;
          SRC_DARK:  seg_q[i] <= 1'b0;
          default:   seg_q[i] <= pattern[i];
        endcase
      end
    end
  end
endmodule

// File: rtl/seg7_latch_decoder.sv
module seg7_latch_decoder
  import seg7_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] bcd_in,
  input  logic              lamp_test_n,
  input  logic              blank_n,
  input  logic              latch_en,
  input  logic [DUTY_W-1:0] duty,
  output logic [SEG_N-1:0]  seg
);
  logic [CODE_W-1:0] held_code;
  logic [CODE_W-1:0] code_now;
  logic [DUTY_W-1:0] dim_count;
  logic              dim_blank;
  logic              any_dark;
  seg_src_e          src;

  seg7_code_store #(.W(CODE_W)) u_store (
    .clk(clk), .rst(rst), .hold(latch_en), .code_in(bcd_in),
    .code_q(held_code), .code_sel(code_now)
  );

  seg7_dimmer #(.W(DUTY_W)) u_dim (
    .clk(clk), .rst(rst), .thresh(duty), .phase(dim_count), .dark(dim_blank)
  );

  always_comb begin
    any_dark = !blank_n || dim_blank;
    src      = pick_src(lamp_test_n, any_dark);
  end

  seg7_glyph_stage #(.N(SEG_N)) u_out (
    .clk(clk), .rst(rst), .src(src), .code(code_now), .seg_q(seg)
  );
endmodule

// File: rtl/seg7_checker.sv
module seg7_checker
  import seg7_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] bcd_in,
  input logic              lamp_test_n,
  input logic              blank_n,
  input logic              latch_en,
  input logic [DUTY_W-1:0] duty,
  input logic [SEG_N-1:0]  seg,
  input logic [CODE_W-1:0] held_code,
  input logic [DUTY_W-1:0] dim_count,
  input logic              dim_blank
);
  a_r1_lamp_lights_all: assert property (@(posedge clk) disable iff (rst)
    !lamp_test_n |=> seg == SEG_ALL_ON);

  a_r2_blank_darkens: assert property (@(posedge clk) disable iff (rst)
    lamp_test_n && !blank_n |=> seg == SEG_ALL_OFF);

  a_r4_hold_keeps_code: assert property (@(posedge clk) disable iff (rst)
    latch_en |=> $stable(held_code));

  a_r5_illegal_dark: assert property (@(posedge clk) disable iff (rst)
    lamp_test_n && !latch_en && !code_is_digit(bcd_in) |=> seg == SEG_ALL_OFF);

  a_r7_counter_steps: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> dim_count == $past(dim_count) + DUTY_W'(1));

  a_r7_dim_darkens: assert property (@(posedge clk) disable iff (rst)
    lamp_test_n && dim_blank |=> seg == SEG_ALL_OFF);

  a_r8_zero_duty_dark: assert property (@(posedge clk) disable iff (rst)
    lamp_test_n && duty == '0 |=> seg == SEG_ALL_OFF);

  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> seg == SEG_ALL_OFF && held_code == '0 && dim_count == '0);
endmodule

bind seg7_latch_decoder seg7_checker u_chk (
  .clk(clk), .rst(rst), .bcd_in(bcd_in), .lamp_test_n(lamp_test_n),
  .blank_n(blank_n), .latch_en(latch_en), .duty(duty), .seg(seg),
  .held_code(held_code), .dim_count(dim_count), .dim_blank(dim_blank)
);

// File: tb/sim_seg7_latch_decoder.sv
module sim_seg7_latch_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] bcd_in = 4'd0;
  logic       lamp_test_n = 1'b1;
  logic       blank_n = 1'b1;
  logic       latch_en = 1'b0;
  logic [7:0] duty = 8'd255;
  logic [6:0] seg;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  logic [6:0] exp_q[$];
  string      tag_q[$];

  // Reference model state
  logic [3:0] m_code = 4'd0;
  logic [7:0] m_cnt  = 8'd0;

  always #2 clk = ~clk;  // 250 MHz

  seg7_latch_decoder u0 (
    .clk(clk), .rst(rst), .bcd_in(bcd_in), .lamp_test_n(lamp_test_n),
    .blank_n(blank_n), .latch_en(latch_en), .duty(duty), .seg(seg)
  );

  // Per-segment digit masks, bit i set when digit i lights the segment (R6).
  function automatic logic [6:0] ref_glyph(input logic [3:0] c);
    logic [9:0] ma = 10'b1110101101, mb = 10'b1110011111, mc = 10'b1111111011;
    logic [9:0] md = 10'b0101101101, me = 10'b0101000101, mf = 10'b1101110001;
    logic [9:0] mg = 10'b1101111100;
    if (c > 4'd9) return 7'd0;
    return {ma[c], mb[c], mc[c], md[c], me[c], mf[c], mg[c]};
  endfunction

  // Driver: apply inputs on the falling edge, predict the result at the rising edge.
  task automatic step(input logic r, input logic [3:0] b, input logic lt,
                      input logic bl, input logic le, input logic [7:0] d,
                      input string force_tag);
    logic [3:0] use_code;
    logic [6:0] e;
    string t;
    @(negedge clk);
    rst = r; bcd_in = b; lamp_test_n = lt; blank_n = bl; latch_en = le; duty = d;
    @(posedge clk);
    if (r) begin
      m_code = 4'd0; m_cnt = 8'd0; e = 7'd0; t = "R9";
    end else begin
      use_code = le ? m_code : b;
      if (!lt)                begin e = 7'h7F; t = "R1"; end
      else if (!bl)           begin e = 7'h00; t = "R2"; end
      else if (m_cnt >= d)    begin e = 7'h00; t = (d == 8'd0 || d == 8'd255) ? "R8" : "R7"; end
      else if (use_code > 9)  begin e = 7'h00; t = "R5"; end
      else begin e = ref_glyph(use_code); t = le ? "R4" : "R3/R6"; end
      m_code = use_code;
      m_cnt  = m_cnt + 8'd1;
    end
    if (force_tag != "") t = force_tag;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  // Monitor: the result predicted at a rising edge is visible by the next
  // falling edge, one cycle after the inputs (R11).
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [6:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (seg !== e) begin
        errors++;
        $display("FAIL %s: seg=%b expected=%b", t, seg, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: cycles=%0d expected<=150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    for (int i = 0; i < 4; i++) step(1, 4'd7, 1, 1, 0, 8'd255, "R9");

    // R3 / R6: every digit passed through, R5: illegal codes
    for (int k = 0; k < 16; k++) step(0, 4'(k), 1, 1, 0, 8'd255, "");
    for (int k = 15; k >= 0; k--) step(0, 4'(k), 1, 1, 0, 8'd255, "");

    // R11: single-cycle change lands exactly one edge later
    step(0, 4'd1, 1, 1, 0, 8'd255, "R11");
    step(0, 4'd8, 1, 1, 0, 8'd255, "R11");
    step(0, 4'd1, 1, 1, 0, 8'd255, "R11");

    // R1: lamp test over blanking, hold and illegal code
    step(0, 4'd2, 0, 0, 0, 8'd255, "R1");
    step(0, 4'd13, 0, 1, 1, 8'd0, "R1");
    // R2: blanking over data
    step(0, 4'd8, 1, 0, 0, 8'd255, "R2");

    // R4: capture 3, then hold while bcd_in moves
    step(0, 4'd3, 1, 1, 0, 8'd255, "");
    for (int k = 0; k < 10; k++) step(0, 4'(k), 1, 1, 1, 8'd255, "R4");
    // R10: held code survives blanking and lamp test
    step(0, 4'd9, 1, 0, 1, 8'd255, "R10");
    step(0, 4'd9, 0, 1, 1, 8'd255, "R10");
    step(0, 4'd5, 1, 1, 1, 8'd255, "R10");
    // R4 / R5: held illegal code stays dark
    step(0, 4'd12, 1, 1, 0, 8'd255, "");
    step(0, 4'd4, 1, 1, 1, 8'd255, "R5");
    step(0, 4'd4, 1, 1, 0, 8'd255, "");

    // R8: zero duty is dark; full duty lets one cycle in 256 go dark
    for (int k = 0; k < 20; k++) step(0, 4'd8, 1, 1, 0, 8'd0, "R8");
    for (int k = 0; k < 300; k++) step(0, 4'd8, 1, 1, 0, 8'd255, "");
    // R7: partial duties
    for (int k = 0; k < 300; k++) step(0, 4'(k % 10), 1, 1, 0, 8'd128, "");
    for (int k = 0; k < 260; k++) step(0, 4'd0, 1, 1, 0, 8'd17, "");

    // R9: reset in mid-run clears code and counter
    step(1, 4'd6, 1, 1, 0, 8'd255, "R9");
    step(0, 4'd6, 1, 1, 1, 8'd255, "R9");
    step(0, 4'd6, 1, 1, 1, 8'd1, "R7");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule